// File: doc/BRIEF.md
# Pattern Generator Pin Driver

This block plays a stream of pattern words out onto a bank of bidirectional pins. Words arrive on a ready/valid input. Each word is held on the pins for a programmable number of clock cycles: the divider value plus one. Playback stays parked until a start pulse arrives. After that, words are taken whenever the stream offers them and the current word's hold time has run out. If the stream goes empty, the last word stays on the pins.

Every pin is shaped by static configuration inputs before it reaches the pad buffer:
- A direction mask. A set bit makes the pin an input and removes its drive.
- An override mask and override data. These replace the streamed value bit by bit.
- A mode bit that selects push-pull or open-drain drive.

The block produces a value and an output enable for each pin. The pad buffers are outside the block.

The sequencer is a three-state machine:
- `ST_IDLE`: after reset, waiting for start. It leaves on a start pulse (transition *arm*) to `ST_STARVED`.
- `ST_STARVED`: armed, with no word pending. It leaves when a valid word is accepted (transition *load*) to `ST_PLAY`.
- `ST_PLAY`: holding a word. When the hold time has run out and a new word is valid, that word is accepted and the machine stays in `ST_PLAY` (transition *chain*). When the hold time has run out and no word is valid, it goes back to `ST_STARVED` (transition *dry*).

Top module: `pattern_pin_driver`

## Requirements
- R1: After reset, ready is 0, every pin value is 0, and with all configuration inputs at 0 every output enable is 1 (all pins are outputs, push-pull, no override, divider 0).
- R2: Before a start pulse, ready stays 0 even while valid is 1, and the pins keep their reset value.
- R3: After a start pulse, the first valid word sees ready 1 in the same cycle. The word is on the pins from the next cycle on.
- R4: With the divider at D and valid held high, accepted words are exactly D+1 cycles apart. Each word stays unchanged on the pins for those D+1 cycles.
- R5: When the stream is empty, the last word stays on the pins and ready is 0 while valid is 0. Once the hold time is over, a newly valid word sees ready 1 in the cycle it appears.
- R6: A pin whose direction bit is 1 has output enable 0 in every mode and with any override setting.
- R7: A pin whose override-mask bit is 1 takes its source value from override data instead of the pattern word.
- R8: In push-pull mode (mode bit 0), each output pin's value is its source value and its enable is 1.
- R9: In open-drain mode (mode bit 1), every pin value is 0. An output pin is enabled only when its source value is 0.
- R10: With the divider at 0, a continuous stream is accepted at one word per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse that arms playback |
| pat_valid_i | input | 1 | Pattern word is valid |
| pat_data_i | input | PIN_W | Pattern word |
| pat_ready_o | output | 1 | Pattern word is accepted this cycle |
| div_i | input | DIV_W | Hold time minus one, in cycles |
| dir_mask_i | input | PIN_W | 1 = pin is an input, 0 = pin is an output |
| ovr_mask_i | input | PIN_W | 1 = pin takes its value from override data |
| ovr_data_i | input | PIN_W | Override values |
| open_drain_i | input | 1 | 0 = push-pull, 1 = open-drain |
| pin_val_o | output | PIN_W | Value driven on each pin |
| pin_oe_o | output | PIN_W | Output enable for each pin |

## Verification
The assertions assume the configuration inputs change only between tests, not while a word is held. They also assume the stream keeps its data stable in any cycle in which it is offered. The bench drives every input on the falling clock edge. It changes the divider and the masks only after a fresh reset or while the sequencer is starved, so the hold-time and word-stability checks see steady settings. Each scenario starts from reset, so the one-time start pulse is exercised once per scenario.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STARVED = 2'd1,
        ST_PLAY    = 2'd2
    } pgd_state_e;
endpackage

// File: rtl/pgd_sequencer.sv
module pgd_sequencer
    import pgd_pkg::*;
#(
    parameter int PIN_W = 16,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pat_valid_i,
    input  logic [PIN_W-1:0] pat_data_i,
    output logic             pat_ready_o,
    input  logic [DIV_W-1:0] div_i,
    output logic [PIN_W-1:0] word_o
);
    pgd_state_e       state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [PIN_W-1:0] word_q;
    logic             hold_done;
    logic             accept;

    assign hold_done = (cnt_q >= div_i);
    assign accept    = pat_ready_o;
    assign word_o    = word_q;

    // next-state and ready
    always_comb begin
        state_d     = state_q;
        pat_ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_STARVED;
            end
            ST_STARVED: begin
                pat_ready_o = pat_valid_i;
                if (pat_valid_i) state_d = ST_PLAY;
            end
            ST_PLAY: begin
                pat_ready_o = pat_valid_i & hold_done;
                if (hold_done && !pat_valid_i) state_d = ST_STARVED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // hold counter and word register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            word_q <= '0;
        end else if (accept) begin
            cnt_q  <= '0;
            word_q <= pat_data_i;
        end else if (state_q == ST_PLAY && !hold_done) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R2
    idle_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !pat_ready_o);
    // R3
    load_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (word_q == $past(pat_data_i)));
    // R4
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(word_q));
    // R5
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pat_ready_o |-> pat_valid_i);
endmodule

// File: rtl/pgd_pin_drive.sv
module pgd_pin_drive #(
    parameter int PIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] word_i,
    input  logic [PIN_W-1:0] dir_mask_i,
    input  logic [PIN_W-1:0] ovr_mask_i,
    input  logic [PIN_W-1:0] ovr_data_i,
    input  logic             open_drain_i,
    output logic [PIN_W-1:0] pin_val_o,
    output logic [PIN_W-1:0] pin_oe_o
);
    for (genvar b = 0; b < PIN_W; b++) begin : g_pin
        logic src;
        assign src          = ovr_mask_i[b] ? ovr_data_i[b] : word_i[b];
        assign pin_val_o[b] = open_drain_i ? 1'b0 : src;
        assign pin_oe_o[b]  = ~dir_mask_i[b] & (~open_drain_i | ~src);
    end

    // R6
    input_pin_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe_o & dir_mask_i) == '0);
    // R9
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_drain_i |-> ((pin_oe_o & ~ovr_mask_i & word_i) == '0));
    // R7
    override_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open_drain_i |-> ((pin_val_o & ovr_mask_i) == (ovr_data_i & ovr_mask_i)));
endmodule

// File: rtl/pattern_pin_driver.sv
module pattern_pin_driver #(
    parameter int PIN_W = 16,
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             pat_valid_i,
    input  logic [PIN_W-1:0] pat_data_i,
    output logic             pat_ready_o,
    input  logic [DIV_W-1:0] div_i,
    input  logic [PIN_W-1:0] dir_mask_i,
    input  logic [PIN_W-1:0] ovr_mask_i,
    input  logic [PIN_W-1:0] ovr_data_i,
    input  logic             open_drain_i,
    output logic [PIN_W-1:0] pin_val_o,
    output logic [PIN_W-1:0] pin_oe_o
);
    logic [PIN_W-1:0] word;

    pgd_sequencer #(.PIN_W(PIN_W), .DIV_W(DIV_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .pat_valid_i (pat_valid_i),
        .pat_data_i  (pat_data_i),
        .pat_ready_o (pat_ready_o),
        .div_i       (div_i),
        .word_o      (word)
    );

    pgd_pin_drive #(.PIN_W(PIN_W)) u_drv (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_i       (word),
        .dir_mask_i   (dir_mask_i),
        .ovr_mask_i   (ovr_mask_i),
        .ovr_data_i   (ovr_data_i),
        .open_drain_i (open_drain_i),
        .pin_val_o    (pin_val_o),
        .pin_oe_o     (pin_oe_o)
    );
endmodule

// File: tb/test_pattern_pin_driver.sv
module test_pattern_pin_driver;
    localparam int W  = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start, valid, od;
    logic [W-1:0]  data, dir, omask, odata;
    logic [DW-1:0] div;
    logic          ready;
    logic [W-1:0]  pval, poe;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pattern_pin_driver #(.PIN_W(W), .DIV_W(DW)) i_pattern_pin_driver (
        .clk(clk), .rst_n(rst_n), .start_i(start), .pat_valid_i(valid),
        .pat_data_i(data), .pat_ready_o(ready), .div_i(div),
        .dir_mask_i(dir), .ovr_mask_i(omask), .ovr_data_i(odata),
        .open_drain_i(od), .pin_val_o(pval), .pin_oe_o(poe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        start = 0; valid = 0; data = '0; div = '0;
        dir = '0; omask = '0; odata = '0; od = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic load_word(logic [W-1:0] w);
        @(negedge clk); valid = 1; data = w;
        #1 chk("R3 ready on first word", ready, 1);
        @(negedge clk); valid = 0;
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 ready", ready, 0);
        chk("R1 pin value", pval, 0);
        chk("R1 output enable", poe, 16'hFFFF);
    endtask

    task automatic t_start_gate();
        do_reset();
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); valid = 1; data = 16'hA5A5;
            #1 chk("R2 ready before start", ready, 0);
        end
        @(negedge clk); valid = 0;
        chk("R2 pins before start", pval, 0);
    endtask

    task automatic t_first_word();
        do_reset();
        pulse_start();
        load_word(16'h1234);
        chk("R3 word on pins", pval, 16'h1234);
    endtask

    task automatic t_rate(int d, string tag);
        int last = 0;
        int i = 0;
        do_reset();
        div = DW'(d);
        pulse_start();
        for (int k = 0; k < 80 && i < 6; k++) begin
            @(negedge clk);
            if (i > 0) chk({tag, " word held"}, pval, 32'h100 + i - 1);
            valid = 1; data = 16'h100 + W'(i);
            #1;
            if (ready) begin
                if (i > 0) chk({tag, " accept spacing"}, k - last, d + 1);
                last = k;
                i++;
            end
        end
        @(negedge clk); valid = 0;
        chk({tag, " word count"}, i, 6);
    endtask

    task automatic t_starve();
        do_reset();
        div = 1;
        pulse_start();
        load_word(16'hBEEF);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            chk("R5 ready low when empty", ready, 0);
            chk("R5 last word held", pval, 16'hBEEF);
        end
        @(negedge clk); valid = 1; data = 16'hCAFE;
        #1 chk("R5 ready on refill", ready, 1);
        @(negedge clk); valid = 0;
        chk("R5 new word", pval, 16'hCAFE);
    endtask

    task automatic t_direction();
        do_reset();
        pulse_start();
        load_word(16'h3C3C);
        dir = 16'h00F0; omask = 16'h0F00; odata = 16'h0A00;
        #1 chk("R6 push-pull enables", poe, 16'hFF0F);
        od = 1;
        #1 chk("R6 open-drain input pins off", poe & 16'h00F0, 0);
        dir = 16'hFFFF;
        #1 chk("R6 all inputs open-drain", poe, 0);
        od = 0;
        #1 chk("R6 all inputs push-pull", poe, 0);
    endtask

    task automatic t_override();
        do_reset();
        pulse_start();
        load_word(16'h00FF);
        omask = 16'h0FF0; odata = 16'h5A5A;
        #1 chk("R7 override mix", pval, 16'h0A5F);
        omask = 16'h0000;
        #1 chk("R7 override off", pval, 16'h00FF);
    endtask

    task automatic t_push_pull();
        do_reset();
        pulse_start();
        load_word(16'hC3A5);
        dir = 16'h8001;
        #1;
        chk("R8 value", pval, 16'hC3A5);
        chk("R8 enable", poe, 16'h7FFE);
    endtask

    task automatic t_open_drain();
        do_reset();
        pulse_start();
        load_word(16'hC3A5);
        od = 1;
        #1;
        chk("R9 value", pval, 0);
        chk("R9 enable", poe, 16'h3C5A);
        dir = 16'h0018;
        #1 chk("R9 enable with inputs", poe, 16'h3C42);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_start_gate();
        t_first_word();
        t_rate(3, "R4");
        t_rate(0, "R10");
        t_starve();
        t_direction();
        t_override();
        t_push_pull();
        t_open_drain();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule